// File: doc/BRIEF.md
# CAN Bus Fault Qualifier

This block decides whether the CAN bus has a wiring fault and how far that fault has been pinned down. It samples the CANH and CANL comparator results on a strobe and tracks the transmit state. Samples taken while the transmitter is recessive can only show that some line sits at a wrong level. When both lines follow a shorted line, there is no telling which one is at fault. Samples taken while the driver is on (dominant) show which line is faulty and what kind of short it has. A verdict becomes final only after the same classification repeats on consecutive bus cycles.

Four status values go to a register file. The first is a summary fault bit. The second is a not-yet-identified bit. The last two are per-line 2-bit short codes, one for CANL and one for CANH, which the register file keeps in separate fields. A register read-and-clear drives a synchronous clear input.

All inputs are plain control and status pins. A sample is taken on every clock in which the strobe is high, and there is no back-pressure.

Top module: `can_bus_fault_qual`

## Requirements
- R1: When reset is active, bus_fault and fault_unid are 0 and both line codes are 00.
- R2: fault_unid is never 1 while bus_fault is 0. It is 1 while a fault is detected but not yet identified. It drops to 0 on the clock that writes the line codes.
- R3: A bus cycle needs three things in order. First, at least one strobe with tx_dom=0 (recessive window). Then at least one strobe with tx_dom=1 (dominant window). The cycle ends when tx_dom falls from 1 to 0, and the outputs update on that clock. A dominant window with no recessive sample before it is discarded and counts for nothing.
- R4: Comparator inputs and output codes per line use one encoding: 00 means the level expected for the current state, 01 short to ground, 10 short to VDD, 11 short to VSUP. The classification of a cycle is three things: whether any recessive sample was non-00, and the last dominant CANH and CANL values. A fault is identified when the same non-clean classification, with a nonzero dominant code, is seen on 5 consecutive cycles. The codes are latched at that point.
- R5: A classification that differs from the previous cycle's restarts the confirmation count at 1. This leaves fault_unid at 1, and the codes latched earlier are kept.
- R6: A cycle with recessive faults but both dominant codes 00 raises bus_fault and fault_unid, and it never leads to identification.
- R7: A recessive strobe with any non-00 comparator sets bus_fault on the next clock. If bus_fault was 0 before, fault_unid is set as well. No dominant phase is needed, which covers an idle bus.
- R8: clr clears bus_fault, fault_unid and the confirmation state on the next clock. The line codes are kept.
- R9: While bus_fault is 1, five consecutive clean cycles clear bus_fault, fault_unid and both codes.
- R10: canl_code takes the dominant CANL comparator value and canh_code takes the dominant CANH value. Each is written independently of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear from the status read-and-clear |
| tx_dom | input | 1 | Transmit state, 1 while the driver is dominant |
| smp_stb | input | 1 | Comparator sample strobe |
| canh_cmp | input | 2 | CANH comparator class |
| canl_cmp | input | 2 | CANL comparator class |
| bus_fault | output | 1 | Some bus fault detected |
| fault_unid | output | 1 | Fault detected but not yet identified |
| canh_code | output | 2 | Identified CANH short code |
| canl_code | output | 2 | Identified CANL short code |

## Verification
Several sequences drive the classification path:
- Runs of identical faulty cycles show where the five-cycle threshold falls, and that the count saturates after it.
- A changed classification partway through a run shows that the count restarts instead of accumulating.
- Cycles that carry only recessive faults set the intermediate status without ever identifying a fault.
- Dominant windows without a recessive sample show that incomplete cycles are rejected.

A lone recessive strobe checks idle-bus detection. Runs of clean cycles check the release. A clear issued between runs shows that the codes are kept while the counter restarts.

// File: rtl/can_fq_pkg.sv
package can_fq_pkg;
  typedef enum logic [1:0] {
    SC_NONE = 2'b00,
    SC_GND  = 2'b01,
    SC_VDD  = 2'b10,
    SC_VSUP = 2'b11
  } short_e;

  typedef struct packed {
    logic   rec_bad;
    short_e h;
    short_e l;
  } cyc_cls_t;
endpackage

// File: rtl/can_fq_window.sv
module can_fq_window
  import can_fq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_dom,
  input  logic       smp_stb,
  input  logic [1:0] canh_cmp,
  input  logic [1:0] canl_cmp,
  output logic       cyc_done,
  output cyc_cls_t   cyc_cls,
  output logic       rec_hit
);
  logic   tx_q, rec_ok, rec_bad, dom_ok;
  short_e dh_q, dl_q;
  logic   fall, any_bad, rec_smp, dom_smp;

  assign fall    = tx_q & ~tx_dom;
  assign any_bad = (canh_cmp != 2'b00) | (canl_cmp != 2'b00);
  assign rec_smp = smp_stb & ~tx_dom;
  assign dom_smp = smp_stb & tx_dom;

  assign cyc_done = fall & rec_ok & dom_ok;
  assign cyc_cls  = '{rec_bad: rec_bad, h: dh_q, l: dl_q};
  assign rec_hit  = rec_smp & any_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q    <= 1'b0;
      rec_ok  <= 1'b0;
      rec_bad <= 1'b0;
      dom_ok  <= 1'b0;
      dh_q    <= SC_NONE;
      dl_q    <= SC_NONE;
    end else begin
      tx_q <= tx_dom;
      if (fall) begin
        rec_ok  <= rec_smp;
        rec_bad <= rec_hit;
        dom_ok  <= 1'b0;
      end else if (rec_smp) begin
        rec_ok  <= 1'b1;
        rec_bad <= rec_bad | any_bad;
      end
      if (dom_smp) begin
        dom_ok <= 1'b1;
        dh_q   <= short_e'(canh_cmp);
        dl_q   <= short_e'(canl_cmp);
      end
    end
  end
endmodule

// File: rtl/can_fq_confirm.sv
module can_fq_confirm
  import can_fq_pkg::*;
#(
  parameter int N_CONFIRM = 5,
  parameter int N_CLEAN   = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       cyc_done,
  input  cyc_cls_t   cyc_cls,
  input  logic       rec_hit,
  output logic       bus_fault,
  output logic       fault_unid,
  output logic [1:0] canh_code,
  output logic [1:0] canl_code
);
  localparam int NMAX = (N_CONFIRM > N_CLEAN) ? N_CONFIRM : N_CLEAN;
  localparam int CW   = $clog2(NMAX + 1);

  logic          fault_q, unid_q, fault_n, unid_n;
  logic [1:0]    h_q, l_q, h_n, l_n;
  logic [CW-1:0] cnt_q, cnt_n, ccnt_q, ccnt_n;
  cyc_cls_t      prev_q, prev_n;
  logic          faulty, line_hit;

  assign faulty   = (cyc_cls != '0);
  assign line_hit = (cyc_cls.h != SC_NONE) | (cyc_cls.l != SC_NONE);

  always_comb begin
    fault_n = fault_q;
    unid_n  = unid_q;
    h_n     = h_q;
    l_n     = l_q;
    cnt_n   = cnt_q;
    ccnt_n  = ccnt_q;
    prev_n  = prev_q;
    if (cyc_done) begin
      if (faulty) begin
        ccnt_n = '0;
        if (cnt_q != '0 && cyc_cls == prev_q)
          cnt_n = (cnt_q == CW'(N_CONFIRM)) ? cnt_q : cnt_q + CW'(1);
        else
          cnt_n = CW'(1);
        prev_n  = cyc_cls;
        fault_n = 1'b1;
        if (cnt_n == CW'(N_CONFIRM) && line_hit) begin
          unid_n = 1'b0;
          h_n    = cyc_cls.h;
          l_n    = cyc_cls.l;
        end else begin
          unid_n = 1'b1;
        end
      end else begin
        cnt_n  = '0;
        prev_n = '0;
        if (fault_q) begin
          if (ccnt_q == CW'(N_CLEAN - 1)) begin
            fault_n = 1'b0;
            unid_n  = 1'b0;
            h_n     = 2'b00;
            l_n     = 2'b00;
            ccnt_n  = '0;
          end else begin
            ccnt_n = ccnt_q + CW'(1);
          end
        end
      end
    end
    if (rec_hit) begin
      if (!fault_n) unid_n = 1'b1;
      fault_n = 1'b1;
    end
    if (clr) begin
      fault_n = 1'b0;
      unid_n  = 1'b0;
      cnt_n   = '0;
      ccnt_n  = '0;
      prev_n  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= 1'b0;
      unid_q  <= 1'b0;
      h_q     <= 2'b00;
      l_q     <= 2'b00;
      cnt_q   <= '0;
      ccnt_q  <= '0;
      prev_q  <= '0;
    end else begin
      fault_q <= fault_n;
      unid_q  <= unid_n;
      h_q     <= h_n;
      l_q     <= l_n;
      cnt_q   <= cnt_n;
      ccnt_q  <= ccnt_n;
      prev_q  <= prev_n;
    end
  end

  assign bus_fault  = fault_q;
  assign fault_unid = unid_q;
  assign canh_code  = h_q;
  assign canl_code  = l_q;
endmodule

// File: rtl/can_bus_fault_qual.sv
module can_bus_fault_qual
  import can_fq_pkg::*;
#(
  parameter int N_CONFIRM = 5,
  parameter int N_CLEAN   = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       tx_dom,
  input  logic       smp_stb,
  input  logic [1:0] canh_cmp,
  input  logic [1:0] canl_cmp,
  output logic       bus_fault,
  output logic       fault_unid,
  output logic [1:0] canh_code,
  output logic [1:0] canl_code
);
  logic     cyc_done, rec_hit;
  cyc_cls_t cyc_cls;

  can_fq_window u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_dom   (tx_dom),
    .smp_stb  (smp_stb),
    .canh_cmp (canh_cmp),
    .canl_cmp (canl_cmp),
    .cyc_done (cyc_done),
    .cyc_cls  (cyc_cls),
    .rec_hit  (rec_hit)
  );

  can_fq_confirm #(
    .N_CONFIRM (N_CONFIRM),
    .N_CLEAN   (N_CLEAN)
  ) u_conf (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .cyc_done   (cyc_done),
    .cyc_cls    (cyc_cls),
    .rec_hit    (rec_hit),
    .bus_fault  (bus_fault),
    .fault_unid (fault_unid),
    .canh_code  (canh_code),
    .canl_code  (canl_code)
  );
endmodule

// File: rtl/can_fq_checker.sv
module can_fq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       clr,
  input logic       tx_dom,
  input logic       smp_stb,
  input logic [1:0] canh_cmp,
  input logic [1:0] canl_cmp,
  input logic       bus_fault,
  input logic       fault_unid,
  input logic [1:0] canh_code,
  input logic [1:0] canl_code
);
  p_unid_needs_fault_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fault_unid |-> bus_fault);

  p_ident_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(fault_unid) && bus_fault) |-> ($past(tx_dom, 2) && !$past(tx_dom)));

  p_canl_write_ident_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (canl_code != $past(canl_code) && canl_code != 2'b00) |-> (bus_fault && !fault_unid));

  p_canh_write_ident_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (canh_code != $past(canh_code) && canh_code != 2'b00) |-> (bus_fault && !fault_unid));

  p_idle_raise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_stb && !tx_dom && (canh_cmp != 2'b00 || canl_cmp != 2'b00) && !clr) |=> bus_fault);

  p_clr_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!bus_fault && !fault_unid));

  p_clr_keeps_codes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> ($stable(canh_code) && $stable(canl_code)));
endmodule

bind can_bus_fault_qual can_fq_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .clr        (clr),
  .tx_dom     (tx_dom),
  .smp_stb    (smp_stb),
  .canh_cmp   (canh_cmp),
  .canl_cmp   (canl_cmp),
  .bus_fault  (bus_fault),
  .fault_unid (fault_unid),
  .canh_code  (canh_code),
  .canl_code  (canl_code)
);

// File: tb/tb_can_bus_fault_qual.sv
module tb_can_bus_fault_qual;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr = 1'b0;
  logic       tx_dom = 1'b0;
  logic       smp_stb = 1'b0;
  logic [1:0] canh_cmp = 2'b00;
  logic [1:0] canl_cmp = 2'b00;
  logic       bus_fault, fault_unid;
  logic [1:0] canh_code, canl_code;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  can_bus_fault_qual dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .tx_dom(tx_dom), .smp_stb(smp_stb),
    .canh_cmp(canh_cmp), .canl_cmp(canl_cmp), .bus_fault(bus_fault),
    .fault_unid(fault_unid), .canh_code(canh_code), .canl_code(canl_code)
  );

  // {rec_h, rec_l, dom_h, dom_l, exp_fault, exp_unid, exp_h, exp_l}
  localparam int NV = 13;
  localparam logic [13:0] VEC [NV] = '{
    {2'b00, 2'b00, 2'b00, 2'b00, 1'b0, 1'b0, 2'b00, 2'b00},
    {2'b01, 2'b01, 2'b00, 2'b01, 1'b1, 1'b1, 2'b00, 2'b00},
    {2'b01, 2'b01, 2'b00, 2'b01, 1'b1, 1'b1, 2'b00, 2'b00},
    {2'b01, 2'b01, 2'b00, 2'b01, 1'b1, 1'b1, 2'b00, 2'b00},
    {2'b01, 2'b01, 2'b00, 2'b01, 1'b1, 1'b1, 2'b00, 2'b00},
    {2'b01, 2'b01, 2'b00, 2'b01, 1'b1, 1'b0, 2'b00, 2'b01},
    {2'b01, 2'b01, 2'b00, 2'b01, 1'b1, 1'b0, 2'b00, 2'b01},
    {2'b11, 2'b11, 2'b11, 2'b00, 1'b1, 1'b1, 2'b00, 2'b01},
    {2'b00, 2'b00, 2'b00, 2'b00, 1'b1, 1'b1, 2'b00, 2'b01},
    {2'b00, 2'b00, 2'b00, 2'b00, 1'b1, 1'b1, 2'b00, 2'b01},
    {2'b00, 2'b00, 2'b00, 2'b00, 1'b1, 1'b1, 2'b00, 2'b01},
    {2'b00, 2'b00, 2'b00, 2'b00, 1'b1, 1'b1, 2'b00, 2'b01},
    {2'b00, 2'b00, 2'b00, 2'b00, 1'b0, 1'b0, 2'b00, 2'b00}
  };

  task automatic chk(input string tag, input logic ef, input logic eu,
                     input logic [1:0] eh, input logic [1:0] el);
    n_chk++;
    if (bus_fault !== ef || fault_unid !== eu || canh_code !== eh || canl_code !== el) begin
      n_fail++;
      $display("FAIL %s: got fault=%b unid=%b h=%b l=%b, expected fault=%b unid=%b h=%b l=%b",
               tag, bus_fault, fault_unid, canh_code, canl_code, ef, eu, eh, el);
    end
  endtask

  // One recessive strobe, one dominant strobe, then the falling edge; outputs settle after it.
  task automatic bus_cycle(input logic [1:0] rh, input logic [1:0] rl,
                           input logic [1:0] dh, input logic [1:0] dl);
    @(negedge clk); tx_dom = 1'b0; smp_stb = 1'b1; canh_cmp = rh; canl_cmp = rl;
    @(negedge clk); tx_dom = 1'b1; smp_stb = 1'b1; canh_cmp = dh; canl_cmp = dl;
    @(negedge clk); tx_dom = 1'b0; smp_stb = 1'b0; canh_cmp = 2'b00; canl_cmp = 2'b00;
    @(negedge clk);
  endtask

  task automatic dom_only(input logic [1:0] dh, input logic [1:0] dl);
    @(negedge clk); tx_dom = 1'b1; smp_stb = 1'b1; canh_cmp = dh; canl_cmp = dl;
    @(negedge clk); tx_dom = 1'b0; smp_stb = 1'b0; canh_cmp = 2'b00; canl_cmp = 2'b00;
    @(negedge clk);
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset state", 1'b0, 1'b0, 2'b00, 2'b00);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", 1'b0, 1'b0, 2'b00, 2'b00);

    // R3: dominant windows without a recessive sample never count
    for (int i = 0; i < 6; i++) dom_only(2'b00, 2'b01);
    chk("R3 dominant-only cycles ignored", 1'b0, 1'b0, 2'b00, 2'b00);

    // Table: R2/R4/R5/R9/R10 identification, restart and release
    for (int v = 0; v < NV; v++) begin
      bus_cycle(VEC[v][13:12], VEC[v][11:10], VEC[v][9:8], VEC[v][7:6]);
      chk($sformatf("R2/R4/R5/R9/R10 table row %0d", v),
          VEC[v][5], VEC[v][4], VEC[v][3:2], VEC[v][1:0]);
    end

    // R6: recessive-only faults never identify
    for (int i = 0; i < 6; i++) bus_cycle(2'b01, 2'b01, 2'b00, 2'b00);
    chk("R6 recessive-only stays unidentified", 1'b1, 1'b1, 2'b00, 2'b00);
    pulse_clr();
    chk("R8 clear after unidentified", 1'b0, 1'b0, 2'b00, 2'b00);

    // R10: CANH short to VDD lands in the CANH field only
    for (int i = 0; i < 5; i++) bus_cycle(2'b10, 2'b10, 2'b10, 2'b00);
    chk("R10 CANH code written", 1'b1, 1'b0, 2'b10, 2'b00);
    pulse_clr();
    chk("R8 clear keeps codes", 1'b0, 1'b0, 2'b10, 2'b00);

    // R5: interruption restarts count
    for (int i = 0; i < 3; i++) bus_cycle(2'b10, 2'b10, 2'b10, 2'b00);
    bus_cycle(2'b01, 2'b01, 2'b00, 2'b01);
    for (int i = 0; i < 4; i++) bus_cycle(2'b10, 2'b10, 2'b10, 2'b00);
    chk("R5 restart leaves fault unidentified", 1'b1, 1'b1, 2'b10, 2'b00);
    bus_cycle(2'b10, 2'b10, 2'b10, 2'b00);
    chk("R4 fifth matching cycle identifies", 1'b1, 1'b0, 2'b10, 2'b00);

    // R7: idle bus, single recessive sample
    pulse_clr();
    chk("R8 clear before idle test", 1'b0, 1'b0, 2'b10, 2'b00);
    @(negedge clk); tx_dom = 1'b0; smp_stb = 1'b1; canh_cmp = 2'b11; canl_cmp = 2'b11;
    @(negedge clk); smp_stb = 1'b0; canh_cmp = 2'b00; canl_cmp = 2'b00;
    chk("R7 idle recessive raise", 1'b1, 1'b1, 2'b10, 2'b00);

    // R1: reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset mid-run", 1'b0, 1'b0, 2'b00, 2'b00);
    rst_n = 1'b1;
    @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule